// File: doc/BRIEF.md
# Self-Calibration Start and Completion Sequencer

This block is the digital control for an on-demand calibration cycle in a pipelined converter. A calibration request arrives on an input that may change at any time relative to the converter clock. The block retimes it, checks that it stays high for enough cycles, and then runs a fixed-length calibration window timed by a cycle counter. The counter stands in for the capacitor-mismatch measurement and the coefficient storage, which are outside this block. The clock must run for the whole window.

A completion status output is high when the converter is in normal conversion mode. It drops as soon as the retimed request is seen rising, stays low while the request is qualified and the window runs, and goes high again when the window ends. A separate busy output is high only during the calibration window, so that downstream logic can discard conversion results. A request that is still high when the window ends does not start another calibration. The request must go low before a new rising edge is accepted.

Top module: `selfcal_sequencer`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising clock edge), cal_done_o is 1 and cal_busy_o is 0. A reset applied during a calibration ends it at once with the same output values.
- R2: If cal_start_i goes high before rising edge k, then cal_done_o is 0 after edge k+1. Across the two-stage retimer this is one to two clock periods after the request.
- R3: A request that stays high for fewer than MIN_HIGH consecutive retimed cycles (N cycles) starts no calibration. cal_busy_o stays 0, and cal_done_o is low for exactly N+1 cycles before it returns to 1. A single low cycle in the request restarts the qualification from the next rising edge.
- R4: A request that stays high for at least MIN_HIGH retimed cycles raises cal_busy_o exactly MIN_HIGH cycles after cal_done_o fell. cal_busy_o then stays high for exactly CAL_CYCLES cycles.
- R5: For a qualified request, cal_done_o stays low for exactly CAL_CYCLES+MIN_HIGH cycles. It returns to 1 on the same edge at which cal_busy_o returns to 0.
- R6: A request held high past the end of the window starts no second calibration. After it is released, cal_done_o stays 1. Only a later low-to-high transition is accepted as a new request.
- R7: A new rising request during the window does not change the window length or restart it.
- R8: cal_busy_o is never 1 while cal_done_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running converter clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cal_start_i | input | 1 | Calibration request, active high, may be asynchronous |
| cal_done_o | output | 1 | 1 = normal conversion mode, 0 = calibration pending or running |
| cal_busy_o | output | 1 | 1 while the calibration window runs; conversion results are to be discarded |

## Verification
The assertions assume that the request meets setup and hold at the first retiming flop, or is held long enough for metastability to settle. They also assume the clock never stops, and that CAL_CYCLES and MIN_HIGH are at least 2. The stimulus drives the request only on falling clock edges, so every transition is sampled cleanly one half period later. It also keeps a one-cycle gap low for at least one clock. The sweep covers every pulse width around the MIN_HIGH threshold, a request held far beyond the window, a retrigger during the window, a one-cycle dip between two short pulses, and a reset in the middle of a run. It uses a shortened window so that all of these fit in a small run.

// File: rtl/selfcal_pkg.sv
// Package: shared types for the self-calibration sequencer.
// Assumes: nothing; pure type declarations.
package selfcal_pkg;
    // Controller phases: idle, request qualification, calibration window
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/selfcal_req_sync.sv
// Module: retimes an asynchronous level request through a flop chain and
// flags the single cycle in which the retimed level goes from low to high.
// Assumes: STAGES >= 2; the request is a level, not a sub-cycle glitch.
module selfcal_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_async_i,
    output logic req_o,
    output logic rise_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              hist;

    // First retiming stage samples the raw request
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= req_async_i;
    end

    // Remaining stages, one flop each
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
        end
    end

    // History flop for edge detection on the retimed level
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= 1'b0;
        else        hist <= chain[LAST];
    end

    assign req_o  = chain[LAST];
    assign rise_o = chain[LAST] & ~hist;

    // A rising edge flag lasts a single cycle (R6)
    assert_rise_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/selfcal_span_counter.sv
// Module: counts consecutive enabled cycles and flags the LIMIT-th one;
// clears whenever the enable drops or the limit is reached.
// Assumes: LIMIT >= 1.
module selfcal_span_counter #(
    parameter int LIMIT = 17400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic last_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] END_VAL = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign last_o = en_i && (cnt == END_VAL);

    // Count while enabled, wrap at the limit, clear when disabled
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (!en_i)   cnt <= '0;
        else if (last_o)  cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end

    // Counter never passes its terminal value (R5)
    assert_count_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= END_VAL);
    // Losing the enable always leaves the counter cleared (R3)
    assert_count_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> cnt == '0);
endmodule

// File: rtl/selfcal_ctrl.sv
// Module: phase controller. Leaves idle on a retimed rising edge, qualifies
// the request width, runs the calibration window, then returns to idle.
// Assumes: rise_i is a one-cycle flag; counters report last on their final
// enabled cycle.
module selfcal_ctrl
    import selfcal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic rise_i,
    input  logic width_last_i,
    input  logic run_last_i,
    output logic width_en_o,
    output logic run_en_o,
    output logic done_o,
    output logic busy_o
);
    seq_state_e state, state_nx;

    // Next-phase decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (rise_i) state_nx = ST_ARM;
            ST_ARM: begin
                if (!req_i)            state_nx = ST_IDLE;
                else if (width_last_i) state_nx = ST_RUN;
            end
            ST_RUN:  if (run_last_i) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assign width_en_o = (state == ST_ARM) && req_i;
    assign run_en_o   = (state == ST_RUN);
    assign busy_o     = (state == ST_RUN);
    assign done_o     = (state == ST_IDLE) && !rise_i;

    // Busy only with completion low (R8)
    assert_busy_not_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o);
    // Completion drops only on a high retimed request (R2)
    assert_done_fall_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_o) |-> req_i);
    // Window starts only after a qualified request (R4)
    assert_run_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(req_i) && $past(state) == ST_ARM);
    // Dropped request during qualification aborts without a window (R3)
    assert_arm_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARM && !req_i) |=> !busy_o && state == ST_IDLE);
    // A rising request during the window does not leave it (R7)
    assert_run_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !run_last_i) |=> busy_o);
endmodule

// File: rtl/selfcal_sequencer.sv
// Module: top of the self-calibration sequencer. Retimes the request,
// qualifies its width, times the calibration window, drives status.
// Assumes: free-running clk; CAL_CYCLES >= 2, MIN_HIGH >= 2, SYNC_STAGES >= 2.
module selfcal_sequencer #(
    parameter int CAL_CYCLES  = 17400,
    parameter int MIN_HIGH    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cal_start_i,
    output logic cal_done_o,
    output logic cal_busy_o
);
    localparam int ARM_SPAN = MIN_HIGH - 1;

    logic req_q, req_rise;
    logic width_en, width_last;
    logic run_en, run_last;

    // Request retiming and edge detection
    selfcal_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .req_async_i(cal_start_i),
        .req_o(req_q), .rise_o(req_rise)
    );

    // Width qualification: counts high cycles after the rising-edge cycle
    selfcal_span_counter #(.LIMIT(ARM_SPAN)) u_width (
        .clk(clk), .rst_n(rst_n), .en_i(width_en), .last_o(width_last)
    );

    // Calibration window timer, placeholder for the measurement engine
    selfcal_span_counter #(.LIMIT(CAL_CYCLES)) u_window (
        .clk(clk), .rst_n(rst_n), .en_i(run_en), .last_o(run_last)
    );

    // Phase controller
    selfcal_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_i(req_q), .rise_i(req_rise),
        .width_last_i(width_last), .run_last_i(run_last),
        .width_en_o(width_en), .run_en_o(run_en),
        .done_o(cal_done_o), .busy_o(cal_busy_o)
    );

    // Completion returns high only at window end or on an aborted request (R5)
    assert_done_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_done_o) |-> $past(cal_busy_o) || !$past(req_q));
endmodule

// File: tb/selfcal_sequencer_tb.sv
module selfcal_sequencer_tb;
    localparam int CAL  = 40;
    localparam int MINH = 4;
    localparam int WIN  = CAL + MINH + 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_r = 1'b0;
    logic cal_done_o, cal_busy_o;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    selfcal_sequencer #(.CAL_CYCLES(CAL), .MIN_HIGH(MINH), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .cal_start_i(start_r),
        .cal_done_o(cal_done_o), .cal_busy_o(cal_busy_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One request pattern: first pulse n1 long, optional second pulse at s2 of n2
    task automatic run_case(input int n1, input int s2, input int n2, input int w,
                            input int exp_low, input int exp_busy, input int exp_bf);
        int first_low = -1, low = 0, busy = 0, bfirst = -1, both = 0;
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            if (!cal_done_o) begin low++; if (first_low < 0) first_low = i; end
            if (cal_busy_o) begin busy++; if (bfirst < 0) bfirst = i; end
            if (cal_busy_o && cal_done_o) both++;
            start_r = (i < n1) || (i >= s2 && i < s2 + n2);
        end
        start_r = 1'b0;
        check("R2 first low sample", first_low, 2);
        check("R5/R3 done low length", low, exp_low);
        check("R4 busy length", busy, exp_busy);
        check("R4 busy start", bfirst, exp_bf);
        check("R8 busy with done high", both, 0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check("R6 idle after release done", int'(cal_done_o), 1);
            check("R6 idle after release busy", int'(cal_busy_o), 0);
        end
    endtask

    initial begin
        #(20ns * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset done", int'(cal_done_o), 1);
        check("R1 reset busy", int'(cal_busy_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3/R4/R5: sweep pulse widths around the threshold
        for (int n = 1; n <= MINH + 3; n++) begin
            if (n >= MINH) run_case(n, WIN, 0, WIN, CAL + MINH, CAL, MINH + 2);
            else           run_case(n, WIN, 0, WIN, n + 1, 0, -1);
        end
        // R6: request held through and past the whole window
        run_case(WIN, WIN, 0, WIN, CAL + MINH, CAL, MINH + 2);
        // R7: retrigger during the window is ignored
        run_case(5, 15, 6, WIN, CAL + MINH, CAL, MINH + 2);
        // R3: two short pulses split by a one-cycle dip, neither qualifies
        run_case(3, 4, 3, WIN, 8, 0, -1);
        // R6: fresh pulse after the held request still works
        run_case(MINH, WIN, 0, WIN, CAL + MINH, CAL, MINH + 2);

        // R1: reset in the middle of a calibration
        start_r = 1'b1;
        repeat (MINH + 1) @(negedge clk);
        start_r = 1'b0;
        repeat (10) @(negedge clk);
        check("R1 busy before mid reset", int'(cal_busy_o), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset done", int'(cal_done_o), 1);
        check("R1 mid reset busy", int'(cal_busy_o), 0);
        rst_n = 1'b1;
        repeat (CAL + 5) begin
            @(negedge clk);
            check("R1 stays idle after reset", int'(cal_busy_o), 0);
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule